// File: doc/BRIEF.md
# MII Management Master

This block is a register-mapped controller for the Ethernet station management link: a two-wire serial path made of a clock (MDC) and a bidirectional data line (MDIO). A host uses a Wishbone classic slave port to set the MDC divider, choose the PHY and register addresses, load the value to write, and issue a command. The host then polls a busy flag. When busy clears, the host reads the 16-bit result of a read frame from a dedicated register.

The block divides the system clock to make MDC and serialises complete management frames. Each frame has a preamble of ones, the start pair, an opcode, both addresses, the turnaround pair and 16 data bits. MDIO is split into an output, an output enable and an input, so the pad-level tristate buffer sits outside the block. A mode register holds a full-duplex control bit, and that bit is also brought out on a pin. The register interface carries no streaming data, so it keeps the plain Wishbone single-beat handshake and there is no valid/ready back-pressure.

Word register map (`wb_adr_i`): 0 mode, 1 MDC divider, 2 command, 3 PHY/register address, 4 write data, 5 read result, 6 status.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The mode register (word 0) resets to 0x0000A000. It is 32-bit read/write and reads back exactly what was written. `full_duplex_o` always equals mode bit 10.
- R2: The MDC period is D system clocks, where D is the divider register (word 1, low 8 bits, read back zero-extended, reset value 10). Values 0 and 1 act as 2. MDC stays low whenever no frame is running.
- R3: The address register (word 3) holds the PHY address in bits [4:0] and the register address in bits [12:8]. All other bits read as zero.
- R4: Writing the command word (word 2) with bit 1 set starts a read frame. The frame sends 32 ones, then 01, then opcode 10, then the 5 PHY address bits and the 5 register address bits, each MSB first. The output enable is released from the first turnaround bit (frame bit 46) onward.
- R5: A command word with bit 2 set and bit 1 clear starts a write frame. It carries opcode 01 and turnaround 10, then the 16 bits of the write-data register (word 4), MSB first.
- R6: Status bit 1 (word 6) reads 1 from the command until the frame of 64 MDC periods ends, then reads 0. A command issued while busy is ignored.
- R7: After a read frame, word 5 holds the 16 bits sampled on the MDC rising edges of frame bits 48 to 63. With no PHY driving the line, the result is 0xFFFF.
- R8: Every access gets `wb_ack_o` for exactly one cycle, in the cycle after the strobe is first seen.
- R9: While a frame runs, `mdio_o` changes only together with a falling edge of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input (pulled high) |
| full_duplex_o | output | 1 | Mode bit 10 |

## Verification
The bench builds the block with its default parameters: a 32-bit data bus, an 8-bit divider and a 32-bit preamble, so every frame is 64 bits long. Divider values from 0 to 12 are used. This covers the clamp to 2, odd splits of the MDC period and a full frame short enough to fit well inside the host's 1024-poll limit. A bench PHY decodes every frame and answers reads only at one address, so the floating-line result of all ones and real data both appear.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int MDATA_W = 16;

  localparam int REG_MODE = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_CMD  = 2;
  localparam int REG_ADDR = 3;
  localparam int REG_TX   = 4;
  localparam int REG_RX   = 5;
  localparam int REG_STAT = 6;

  localparam int CMD_RD_BIT = 1;
  localparam int CMD_WR_BIT = 2;
  localparam int STAT_BUSY_BIT = 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 3,
  parameter int DIV_W    = 8,
  parameter logic [31:0] MODE_RST = 32'h0000_A000,
  parameter int DIV_RST  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [AW-1:0]       wb_adr_i,
  input  logic [DW-1:0]       wb_dat_i,
  output logic [DW-1:0]       wb_dat_o,
  output logic                wb_ack_o,
  input  logic                busy,
  input  logic [MDATA_W-1:0]  rx_data,
  output logic [DW-1:0]       mode_q,
  output logic [DIV_W-1:0]    div_q,
  output logic [PHY_W-1:0]    phy_q,
  output logic [REG_W-1:0]    reg_q,
  output logic [MDATA_W-1:0]  tx_q,
  output logic                start,
  output mdio_op_e            start_op
);
  logic accept;
  logic [DW-1:0] rd_mux;

  assign accept = wb_cyc_i && wb_stb_i && !wb_ack_o;

  always_comb begin
    start    = accept && wb_we_i && (int'(wb_adr_i) == REG_CMD) && !busy &&
               (wb_dat_i[CMD_RD_BIT] || wb_dat_i[CMD_WR_BIT]);
    start_op = wb_dat_i[CMD_RD_BIT] ? OP_READ : OP_WRITE;
  end

  always_comb begin
    rd_mux = '0;
    case (int'(wb_adr_i))
      REG_MODE: rd_mux = mode_q;
      REG_DIV:  rd_mux = DW'(div_q);
      REG_ADDR: rd_mux = DW'({3'b000, reg_q, 3'b000, phy_q});
      REG_TX:   rd_mux = DW'(tx_q);
      REG_RX:   rd_mux = DW'(rx_data);
      REG_STAT: rd_mux[STAT_BUSY_BIT] = busy;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
      mode_q   <= DW'(MODE_RST);
      div_q    <= DIV_W'(DIV_RST);
      phy_q    <= '0;
      reg_q    <= '0;
      tx_q     <= '0;
    end else begin
      wb_ack_o <= accept;
      if (accept) begin
        wb_dat_o <= rd_mux;
        if (wb_we_i) begin
          case (int'(wb_adr_i))
            REG_MODE: mode_q <= wb_dat_i;
            REG_DIV:  div_q  <= wb_dat_i[DIV_W-1:0];
            REG_ADDR: begin
              phy_q <= wb_dat_i[PHY_W-1:0];
              reg_q <= wb_dat_i[8 +: REG_W];
            end
            REG_TX:   tx_q <= wb_dat_i[MDATA_W-1:0];
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] half;

  assign eff      = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign half     = eff >> 1;
  assign rise_evt = run && (cnt == half - DIV_W'(1));
  assign fall_evt = run && (cnt >= eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_evt ? '0 : cnt + DIV_W'(1);
      if (rise_evt)      mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  mdio_op_e           start_op,
  input  logic [PHY_W-1:0]   phy,
  input  logic [REG_W-1:0]   regad,
  input  logic [MDATA_W-1:0] tx,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               busy,
  output logic [MDATA_W-1:0] rx_data
);
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + MDATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam int TA_IDX    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_IDX  = TA_IDX + 2;

  logic [FRAME_LEN-1:0] sh;
  logic [IDX_W-1:0]     idx;
  logic                 is_rd;
  logic [FRAME_LEN-1:0] frame;
  logic                 rd_req;

  assign rd_req = (start_op == OP_READ);
  assign frame  = {{PRE_LEN{1'b1}}, 2'b01, start_op, phy, regad,
                   rd_req ? 2'b11 : 2'b10,
                   rd_req ? {MDATA_W{1'b1}} : tx};
  assign mdio_o = sh[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else if (!busy) begin
      if (start) begin
        sh      <= frame;
        idx     <= '0;
        is_rd   <= rd_req;
        busy    <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_evt && is_rd && (idx >= IDX_W'(DATA_IDX)))
        rx_data <= {rx_data[MDATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (idx == IDX_W'(FRAME_LEN - 1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx <= idx + IDX_W'(1);
          sh  <= sh << 1;
          if (is_rd && (idx + IDX_W'(1) == IDX_W'(TA_IDX)))
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_adr_i,
  input  logic [DW-1:0] wb_dat_i,
  output logic [DW-1:0] wb_dat_o,
  output logic          wb_ack_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i,
  output logic          full_duplex_o
);
  logic [DW-1:0]      mode_q;
  logic [DIV_W-1:0]   div_q;
  logic [PHY_W-1:0]   phy_q;
  logic [REG_W-1:0]   reg_q;
  logic [MDATA_W-1:0] tx_q;
  logic [MDATA_W-1:0] rx_data;
  logic               start;
  mdio_op_e           start_op;
  logic               busy;
  logic               rise_evt;
  logic               fall_evt;

  assign full_duplex_o = mode_q[10];

  mdio_regs #(.DW(DW), .AW(AW), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
    .wb_ack_o(wb_ack_o), .busy(busy), .rx_data(rx_data),
    .mode_q(mode_q), .div_q(div_q), .phy_q(phy_q), .reg_q(reg_q),
    .tx_q(tx_q), .start(start), .start_op(start_op)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc_o), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .phy(phy_q), .regad(reg_q), .tx(tx_q),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe_o), .busy(busy), .rx_data(rx_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc,
  input logic          stb,
  input logic          we,
  input logic [AW-1:0] adr,
  input logic [DW-1:0] dat_i,
  input logic          ack,
  input logic          mdc,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic          busy,
  input logic          start,
  input logic          full_duplex
);
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_ack_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);
  assert_mdc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_oe_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  assert_mdio_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_duplex_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack && we && (int'(adr) == REG_MODE)) |=>
      (full_duplex == $past(dat_i[10])));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
  .adr(wb_adr_i), .dat_i(wb_dat_i), .ack(wb_ack_o), .mdc(mdc_o),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe_o), .busy(busy), .start(start),
  .full_duplex(full_duplex_o)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [2:0]  adr = '0;
  logic [31:0] dat_w = '0;
  logic [31:0] dat_r;
  logic        ack, mdc, mdo, mdoe, duplex;
  logic        mdi;

  always #2.5 clk = ~clk;

  // bench PHY
  int          phy_cnt = 0;
  logic [63:0] frm = '0;
  bit          phy_drv = 0;
  logic        phy_val = 1'b1;
  bit          phy_on = 1;
  logic [4:0]  phy_addr_b = 5'd7;
  logic [15:0] phy_data = 16'h0;
  int          cycles = 0;
  int          last_rise = 0;
  int          last_per = 0;

  assign mdi = mdoe ? mdo : (phy_drv ? phy_val : 1'b1);

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat_w), .wb_dat_o(dat_r), .wb_ack_o(ack),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi),
    .full_duplex_o(duplex)
  );

  always @(posedge clk) cycles++;

  always @(posedge mdc) begin
    if (phy_cnt < 64) frm[63-phy_cnt] = mdi;
    phy_cnt++;
    if (phy_cnt > 1) last_per = cycles - last_rise;
    last_rise = cycles;
  end

  always @(negedge mdc) begin
    phy_drv = 0;
    if (phy_on && phy_cnt >= 47 && phy_cnt < 64 && frm[29:28] == 2'b10 &&
        frm[27:23] == phy_addr_b) begin
      phy_drv = 1;
      phy_val = (phy_cnt == 47) ? 1'b0 : phy_data[63-phy_cnt];
    end
  end

  int nvec = 0, nbad = 0;
  bit finished = 0;
  int ack_wait;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
    int w = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; dat_w = d;
    do begin @(negedge clk); w++; end while (!ack && w < 8);
    ack_wait = w;
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [31:0] d);
    int w = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    do begin @(negedge clk); w++; end while (!ack && w < 8);
    ack_wait = w;
    d = dat_r;
    cyc = 0; stb = 0;
  endtask

  function automatic int eff_div(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, pa, ra,
            wr ? 2'b10 : 2'b11, wr ? d : 16'hFFFF};
  endfunction

  task automatic poll_done(output int polls);
    logic [31:0] s;
    polls = 0;
    do begin
      wb_read(3'd6, s);
      if (polls == 0) chk("R6 busy seen after command", 64'(s[1]), 64'd1);
      polls++;
    end while (s[1] && polls < 1024);
    chk("R6 busy cleared within poll limit", 64'(s[1]), 64'd0);
  endtask

  task automatic clear_phy();
    phy_cnt = 0; phy_drv = 0; frm = '0;
  endtask

  task automatic do_txn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] d, input int div);
    int polls;
    logic [31:0] r;
    wb_write(3'd1, 32'(div));
    wb_write(3'd3, {19'h0, ra, 3'b000, pa});
    wb_write(3'd4, {16'h0, d});
    clear_phy();
    wb_write(3'd2, wr ? 32'h4 : 32'h2);
    poll_done(polls);
    chk("R6 frame length in MDC periods", 64'(phy_cnt), 64'd64);
    chk("R2 MDC period", 64'(last_per), 64'(eff_div(div)));
    chk("R2 MDC low and line released when idle", {62'h0, mdc, mdoe}, 64'd0);
    if (wr) begin
      chk("R5 R9 write frame", frm, exp_frame(1, pa, ra, d));
    end else begin
      chk("R4 read frame header", 64'(frm[63:18]), 64'(exp_frame(0, pa, ra, d) >> 18));
      wb_read(3'd5, r);
      chk("R7 read result", 64'(r),
          (phy_on && pa == phy_addr_b) ? 64'(phy_data) : 64'h0000_FFFF);
    end
  endtask

  initial begin
    #(195000 * 5.0);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int polls;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state and register access
    wb_read(3'd0, r);
    chk("R1 mode reset value", 64'(r), 64'h0000_A000);
    chk("R8 ack one cycle after strobe", 64'(ack_wait), 64'd1);
    @(negedge clk);
    chk("R8 ack drops after one cycle", 64'(ack), 64'd0);
    chk("R1 duplex pin at reset", 64'(duplex), 64'd0);
    chk("R2 MDC low after reset", 64'(mdc), 64'd0);
    wb_read(3'd6, r);
    chk("R6 status idle after reset", 64'(r), 64'd0);
    wb_read(3'd1, r);
    chk("R2 divider reset value", 64'(r), 64'd10);

    wb_write(3'd0, 32'h0000_A400);
    chk("R8 write ack timing", 64'(ack_wait), 64'd1);
    wb_read(3'd0, r);
    chk("R1 duplex readback", 64'(r), 64'h0000_A400);
    chk("R1 duplex pin set", 64'(duplex), 64'd1);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] m;
      m = $urandom;
      wb_write(3'd0, m);
      wb_read(3'd0, r);
      chk("R1 mode random readback", 64'(r), 64'(m));
      chk("R1 duplex pin follows bit 10", 64'(duplex), 64'(m[10]));
    end

    wb_write(3'd3, 32'hFFFF_FFFF);
    wb_read(3'd3, r);
    chk("R3 address field layout", 64'(r), 64'h0000_1F1F);
    wb_write(3'd1, 32'h0000_01AB);
    wb_read(3'd1, r);
    chk("R2 divider width", 64'(r), 64'h0000_00AB);

    // directed frames
    phy_on = 0;
    do_txn(0, 5'd7, 5'h16, 16'h0, 10);          // no PHY: all ones
    phy_on = 1; phy_data = 16'h1234;
    do_txn(0, 5'd7, 5'h16, 16'h0, 10);
    phy_data = 16'hA5C3;
    do_txn(0, 5'd3, 5'h01, 16'h0, 4);           // other address: floats
    do_txn(1, 5'h1F, 5'h1F, 16'h8001, 2);
    do_txn(0, 5'd7, 5'h00, 16'h0, 0);           // clamp to 2
    do_txn(1, 5'd0, 5'h0A, 16'h5A5A, 1);
    do_txn(0, 5'd7, 5'h1F, 16'h0, 3);           // odd divider

    // command while busy is ignored
    phy_data = 16'h0F0F;
    wb_write(3'd1, 32'd6);
    wb_write(3'd3, {19'h0, 5'h02, 3'b000, 5'd7});
    wb_write(3'd4, 32'h0000_BEEF);
    clear_phy();
    wb_write(3'd2, 32'h2);
    wb_write(3'd2, 32'h4);
    poll_done(polls);
    chk("R6 second command ignored: one frame", 64'(phy_cnt), 64'd64);
    chk("R6 second command ignored: opcode", 64'(frm[29:28]), 64'(2'b10));
    wb_read(3'd5, r);
    chk("R7 result after ignored command", 64'(r), 64'h0000_0F0F);

    // random frames
    for (int i = 0; i < 20; i++) begin
      bit wr;
      logic [4:0] pa, ra;
      logic [15:0] d;
      int dv;
      wr = 1'($urandom);
      pa = ($urandom % 2) ? 5'd7 : 5'($urandom);
      ra = 5'($urandom);
      d  = 16'($urandom);
      dv = $urandom % 13;
      phy_on = 1'($urandom);
      phy_data = 16'($urandom);
      do_txn(wr, pa, ra, d, dv);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule